// File: doc/BRIEF.md
# Eight-bit Timer/Counter with Shared Prescaler

This block is an 8-bit up-counter that a processor can load and read. It advances once per instruction cycle, or on a chosen edge of an external pin after that pin has passed through a two-stage synchronizer. One programmable prescaler sits in front of the counter, or it is handed to a watchdog path, which is not modelled here. When the prescaler is handed off, the counter counts every qualifying event undivided. The clock `clk` runs at the instruction-cycle rate, so one clock is one instruction cycle.

A 7-bit control register selects the count source, the active pin edge, the prescaler owner, the division ratio and the interrupt enable. A wrap from 0xFF to 0x00 sets a sticky overflow flag that software clears through a strobe. The interrupt request is the flag gated by the enable. While the sleep input is high the counter and the prescaler are frozen, so the timer cannot produce a wake-up event. A load of the count blocks counting for two cycles and restarts the prescaler.

Top module: `ttmr_top`

## Requirements
- R1: After reset the count reads 0x00, the control register reads 0x3F, the overflow flag and the interrupt request are low, and the watchdog-assignment output is high.
- R2: A count write sets the count to the written value on the next clock edge. A control write sets the control register, and the register reads back the written value. The control fields are: bits [2:0] ratio, bit 3 prescaler-to-watchdog, bit 4 falling-edge select, bit 5 external source, bit 6 interrupt enable.
- R3: With bit 5 = 0 and bit 3 = 1, the count increases by exactly one on each clock edge.
- R4: After a count write at edge k, edges k+1 and k+2 do not change the count. Edge k+3 is the first edge that can advance it.
- R5: With bit 5 = 1 and bit 4 = 0, a rising pin transition is counted. The pin is sampled at edge p, and the count changes at edge p+2. Falling transitions are not counted.
- R6: With bit 5 = 1 and bit 4 = 1, only falling pin transitions are counted, with the same latency as in R5.
- R7: With bit 3 = 0, the counter advances once every 2^(ratio+1) source events (1:2 up to 1:256).
- R8: The prescaler restarts from zero on every count write and on every control write that changes bit 3.
- R9: A wrap from 0xFF to 0x00 caused by counting sets the overflow flag. The flag stays set until the flag-clear strobe. Loading 0x00 does not set the flag.
- R10: The interrupt request is high exactly when the overflow flag and bit 6 are both set.
- R11: While the sleep input is high, neither the count nor the prescaler advances.
- R12: The watchdog-assignment output equals control bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Instruction-cycle clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cntWrEn | input | 1 | Count write strobe |
| cntWrData | input | 8 | Value to load into the count |
| cntRdData | output | 8 | Current count |
| cfgWrEn | input | 1 | Control register write strobe |
| cfgWrData | input | 7 | Control register write value |
| cfgRdData | output | 7 | Control register contents |
| extPin | input | 1 | Asynchronous external count input |
| sleepIn | input | 1 | High while the device sleeps |
| flagClr | input | 1 | Software clear of the overflow flag |
| ovfFlag | output | 1 | Sticky overflow flag |
| irqReq | output | 1 | Interrupt request |
| wdtPrescSel | output | 1 | High when the prescaler belongs to the watchdog path |

## Verification
The counting function is driven from a vector table. Each vector pairs a control setting and a load value with a wait length. The expected count is computed from the load-inhibit window and the division ratio. Wait lengths one cycle either side of each boundary separate a correct two-cycle inhibit from an off-by-one, and each ratio from its neighbour. Pin toggles in rising and in falling mode separate edge selection from level counting and measure the synchronizer latency exactly. The sleep, prescaler-restart and wrap cases use sequences in which a missing freeze, a stale prescaler or a missing flag set yields a count or flag value different from the correct design.

// File: rtl/ttmr_pkg.sv
package ttmr_pkg;
  localparam int RATIO_W = 3;
  localparam int CFG_W   = RATIO_W + 4;

  // Control register layout, low bits first: ratio, psToWdt, edgeFall, srcExt, irqEn
  typedef struct packed {
    logic               irqEn;
    logic               srcExt;
    logic               edgeFall;
    logic               psToWdt;
    logic [RATIO_W-1:0] ratio;
  } ttmr_cfg_t;

  localparam ttmr_cfg_t CFG_RESET = '{irqEn: 1'b0, srcExt: 1'b1, edgeFall: 1'b1,
                                      psToWdt: 1'b1, ratio: '1};

  // Strobes from the control section to the datapath
  typedef struct packed {
    logic load;   // count register write
    logic tick;   // qualified source event (already gated by sleep and inhibit)
    logic psClr;  // restart the prescaler
  } ttmr_strobe_t;
endpackage

// File: rtl/ttmr_ctrl.sv
module ttmr_ctrl
  import ttmr_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int INHIBIT_CYC = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cntWrEn,
  input  logic               cfgWrEn,
  input  logic [CFG_W-1:0]   cfgWrData,
  input  logic               extPin,
  input  logic               sleepIn,
  output ttmr_cfg_t          cfgQ,
  output ttmr_strobe_t       strobe
);
  localparam int INH_W = $clog2(INHIBIT_CYC + 1);

  ttmr_cfg_t        cfgNext;
  logic [INH_W-1:0] inhibitCnt;
  logic [SYNC_STAGES:0] syncQ;
  logic             syncCur;
  logic             syncPrev;
  logic             pinEdge;
  logic             srcEvent;
  logic             assignChange;

  assign cfgNext = ttmr_cfg_t'(cfgWrData);

  // Control register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cfgQ <= CFG_RESET;
    else if (cfgWrEn) cfgQ <= cfgNext;
  end

  // Pin synchronizer plus one extra stage for edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '0;
    else syncQ <= {syncQ[SYNC_STAGES-1:0], extPin};
  end

  assign syncCur  = syncQ[SYNC_STAGES-1];
  assign syncPrev = syncQ[SYNC_STAGES];

  always_comb begin
    if (cfgQ.edgeFall) pinEdge = syncPrev & ~syncCur;
    else               pinEdge = syncCur & ~syncPrev;
  end

  assign srcEvent = cfgQ.srcExt ? pinEdge : 1'b1;

  // Hold-off window after a count write
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) inhibitCnt <= '0;
    else if (cntWrEn) inhibitCnt <= INH_W'(INHIBIT_CYC);
    else if (inhibitCnt != '0) inhibitCnt <= inhibitCnt - INH_W'(1);
  end

  assign assignChange = cfgWrEn && (cfgNext.psToWdt != cfgQ.psToWdt);

  always_comb begin
    strobe.load  = cntWrEn;
    strobe.tick  = srcEvent && !sleepIn && (inhibitCnt == '0) && !cntWrEn;
    strobe.psClr = cntWrEn || assignChange;
  end
endmodule

// File: rtl/ttmr_datapath.sv
module ttmr_datapath
  import ttmr_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int PS_W  = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  ttmr_strobe_t       strobe,
  input  logic               psToWdt,
  input  logic [RATIO_W-1:0] ratio,
  input  logic [CNT_W-1:0]   loadData,
  input  logic               flagClr,
  output logic [CNT_W-1:0]   count,
  output logic               flag
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [PS_W-1:0] psCnt;
  logic [PS_W:0]   psMaskWide;
  logic [PS_W-1:0] psMask;
  logic            psHit;
  logic            incr;
  logic            wrap;

  // Division mask: 2^(ratio+1) - 1
  always_comb begin
    psMaskWide = ((PS_W+1)'(1) << (int'(ratio) + 1)) - (PS_W+1)'(1);
    psMask     = psMaskWide[PS_W-1:0];
  end

  assign psHit = (psCnt & psMask) == psMask;
  assign incr  = strobe.tick && (psToWdt || psHit);
  assign wrap  = incr && !strobe.load && (count == CNT_MAX);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) psCnt <= '0;
    else if (strobe.psClr) psCnt <= '0;
    else if (strobe.tick && !psToWdt) psCnt <= psCnt + PS_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) count <= '0;
    else if (strobe.load) count <= loadData;
    else if (incr) count <= count + CNT_W'(1);
  end

  // Set has priority over the software clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) flag <= 1'b0;
    else if (wrap) flag <= 1'b1;
    else if (flagClr) flag <= 1'b0;
  end
endmodule

// File: rtl/ttmr_top.sv
module ttmr_top
  import ttmr_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int PS_W        = 8,
  parameter int SYNC_STAGES = 2,
  parameter int INHIBIT_CYC = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cntWrEn,
  input  logic [CNT_W-1:0] cntWrData,
  output logic [CNT_W-1:0] cntRdData,
  input  logic             cfgWrEn,
  input  logic [CFG_W-1:0] cfgWrData,
  output logic [CFG_W-1:0] cfgRdData,
  input  logic             extPin,
  input  logic             sleepIn,
  input  logic             flagClr,
  output logic             ovfFlag,
  output logic             irqReq,
  output logic             wdtPrescSel
);
  ttmr_cfg_t    cfgQ;
  ttmr_strobe_t strobe;

  ttmr_ctrl #(
    .SYNC_STAGES(SYNC_STAGES),
    .INHIBIT_CYC(INHIBIT_CYC)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cntWrEn  (cntWrEn),
    .cfgWrEn  (cfgWrEn),
    .cfgWrData(cfgWrData),
    .extPin   (extPin),
    .sleepIn  (sleepIn),
    .cfgQ     (cfgQ),
    .strobe   (strobe)
  );

  ttmr_datapath #(
    .CNT_W(CNT_W),
    .PS_W (PS_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .psToWdt (cfgQ.psToWdt),
    .ratio   (cfgQ.ratio),
    .loadData(cntWrData),
    .flagClr (flagClr),
    .count   (cntRdData),
    .flag    (ovfFlag)
  );

  assign cfgRdData   = cfgQ;
  assign irqReq      = ovfFlag && cfgQ.irqEn;
  assign wdtPrescSel = cfgQ.psToWdt;
endmodule

// File: rtl/ttmr_checker.sv
module ttmr_checker #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             cntWrEn,
  input logic [CNT_W-1:0] cntWrData,
  input logic [CNT_W-1:0] cntRdData,
  input logic             irqEnBit,
  input logic             sleepIn,
  input logic             flagClr,
  input logic             ovfFlag,
  input logic             irqReq
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  p_load_r2: assert property (@(posedge clk) disable iff (!rstN)
    $past(cntWrEn) |-> cntRdData == $past(cntWrData));

  p_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(cntWrEn) && cntRdData != $past(cntRdData))
      |-> cntRdData == CNT_W'($past(cntRdData) + CNT_W'(1)));

  p_hold_first_r4: assert property (@(posedge clk) disable iff (!rstN)
    ($past(cntWrEn, 2) && !$past(cntWrEn)) |-> cntRdData == $past(cntRdData));

  p_hold_second_r4: assert property (@(posedge clk) disable iff (!rstN)
    ($past(cntWrEn, 3) && !$past(cntWrEn, 2) && !$past(cntWrEn))
      |-> cntRdData == $past(cntRdData));

  p_wrap_sets_r9: assert property (@(posedge clk) disable iff (!rstN)
    ($past(cntRdData) == CNT_MAX && cntRdData == '0 && !$past(cntWrEn)) |-> ovfFlag);

  p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    ($past(ovfFlag) && !$past(flagClr)) |-> ovfFlag);

  p_irq_needs_flag_r10: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> (ovfFlag && irqEnBit));

  p_sleep_freeze_r11: assert property (@(posedge clk) disable iff (!rstN)
    ($past(sleepIn) && !$past(cntWrEn)) |-> cntRdData == $past(cntRdData));
endmodule

bind ttmr_top ttmr_checker #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .cntWrEn  (cntWrEn),
  .cntWrData(cntWrData),
  .cntRdData(cntRdData),
  .irqEnBit (cfgRdData[6]),
  .sleepIn  (sleepIn),
  .flagClr  (flagClr),
  .ovfFlag  (ovfFlag),
  .irqReq   (irqReq)
);

// File: tb/ttmr_top_bench.sv
module ttmr_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 10;

  typedef struct packed {
    logic [6:0]  cfg;
    logic [7:0]  load;
    logic [15:0] waitN;
    logic [7:0]  expCnt;
  } vec_t;

  // Expected count = load + max(0, waitN-2) / divisor
  localparam vec_t VECS [NVEC] = '{
    '{7'h08, 8'h10, 16'd10,  8'h18},  // R3 undivided
    '{7'h08, 8'h20, 16'd2,   8'h20},  // R4 still inside hold-off
    '{7'h08, 8'h20, 16'd3,   8'h21},  // R4 first counted edge
    '{7'h00, 8'h00, 16'd12,  8'h05},  // R7 1:2
    '{7'h01, 8'h00, 16'd18,  8'h04},  // R7 1:4
    '{7'h02, 8'h40, 16'd27,  8'h43},  // R7 1:8
    '{7'h07, 8'h00, 16'd263, 8'h01},  // R7 1:256
    '{7'h07, 8'h00, 16'd257, 8'h00},  // R7 one event short of 256
    '{7'h00, 8'h30, 16'd3,   8'h30},  // R8 write restarts a full prescaler
    '{7'h48, 8'hFE, 16'd4,   8'h00}   // R9 wrap
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cntWrEn = 1'b0;
  logic [7:0] cntWrData = '0;
  logic [7:0] cntRdData;
  logic       cfgWrEn = 1'b0;
  logic [6:0] cfgWrData = '0;
  logic [6:0] cfgRdData;
  logic       extPin = 1'b0;
  logic       sleepIn = 1'b0;
  logic       flagClr = 1'b0;
  logic       ovfFlag;
  logic       irqReq;
  logic       wdtPrescSel;

  int checkCnt = 0;
  int failCnt  = 0;
  logic [7:0] snap;

  always #(CLK_PERIOD/2) clk = ~clk;

  ttmr_top u_ttmr_top (
    .clk(clk), .rstN(rstN),
    .cntWrEn(cntWrEn), .cntWrData(cntWrData), .cntRdData(cntRdData),
    .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData), .cfgRdData(cfgRdData),
    .extPin(extPin), .sleepIn(sleepIn), .flagClr(flagClr),
    .ovfFlag(ovfFlag), .irqReq(irqReq), .wdtPrescSel(wdtPrescSel)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wrCfg(input logic [6:0] v);
    @(negedge clk); cfgWrEn = 1'b1; cfgWrData = v;
    @(negedge clk); cfgWrEn = 1'b0;
  endtask

  task automatic wrCnt(input logic [7:0] v);
    @(negedge clk); cntWrEn = 1'b1; cntWrData = v;
    @(negedge clk); cntWrEn = 1'b0;
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    waitCyc(3);
    rstN = 1'b1;
    waitCyc(1);
    // R1 reset state
    chk("R1 count", cntRdData, 8'h00);
    chk("R1 cfg", {1'b0, cfgRdData}, 8'h3F);
    chk("R1 flag", {7'd0, ovfFlag}, 8'h00);
    chk("R1 irq", {7'd0, irqReq}, 8'h00);
    chk("R1 wdt sel", {7'd0, wdtPrescSel}, 8'h01);
    waitCyc(5);
    chk("R1 idle count", cntRdData, 8'h00);

    // R2 / R12 control readback and assignment output
    wrCfg(7'h55);
    chk("R2 cfg readback", {1'b0, cfgRdData}, 8'h55);
    chk("R12 wdt sel low", {7'd0, wdtPrescSel}, 8'h00);
    wrCfg(7'h08);
    chk("R12 wdt sel high", {7'd0, wdtPrescSel}, 8'h01);
    @(negedge clk); cntWrEn = 1'b1; cntWrData = 8'hA7;
    @(negedge clk); cntWrEn = 1'b0;
    chk("R2 count load", cntRdData, 8'hA7);

    // Vector table: R3 R4 R7 R8 R9
    for (int i = 0; i < NVEC; i++) begin
      wrCfg(VECS[i].cfg);
      wrCnt(VECS[i].load);
      waitCyc(int'(VECS[i].waitN));
      chk($sformatf("R3/R4/R7/R8/R9 vector %0d", i), cntRdData, VECS[i].expCnt);
    end

    // R9 / R10 flag and interrupt after the wrap of the last vector
    chk("R9 flag set", {7'd0, ovfFlag}, 8'h01);
    chk("R10 irq with enable", {7'd0, irqReq}, 8'h01);
    wrCfg(7'h08);
    chk("R10 irq masked", {7'd0, irqReq}, 8'h00);
    waitCyc(3);
    chk("R9 flag sticky", {7'd0, ovfFlag}, 8'h01);
    @(negedge clk); flagClr = 1'b1;
    @(negedge clk); flagClr = 1'b0;
    chk("R9 flag cleared", {7'd0, ovfFlag}, 8'h00);

    // R5 rising edges of the external pin
    wrCfg(7'h28);
    wrCnt(8'h00);
    waitCyc(3);
    chk("R9 load zero no flag", {7'd0, ovfFlag}, 8'h00);
    extPin = 1'b1;
    waitCyc(2);
    chk("R5 before latency", cntRdData, 8'h00);
    waitCyc(1);
    chk("R5 rise counted", cntRdData, 8'h01);
    extPin = 1'b0;
    waitCyc(4);
    chk("R5 fall ignored", cntRdData, 8'h01);
    for (int j = 0; j < 3; j++) begin
      extPin = 1'b1; waitCyc(3);
      extPin = 1'b0; waitCyc(3);
    end
    chk("R5 pulse train", cntRdData, 8'h04);

    // R6 falling edges
    wrCfg(7'h38);
    wrCnt(8'h00);
    waitCyc(3);
    extPin = 1'b1;
    waitCyc(4);
    chk("R6 rise ignored", cntRdData, 8'h00);
    extPin = 1'b0;
    waitCyc(2);
    chk("R6 before latency", cntRdData, 8'h00);
    waitCyc(1);
    chk("R6 fall counted", cntRdData, 8'h01);

    // R11 sleep freezes counting
    wrCfg(7'h08);
    wrCnt(8'h50);
    waitCyc(2);
    sleepIn = 1'b1;
    waitCyc(10);
    chk("R11 frozen", cntRdData, 8'h50);
    sleepIn = 1'b0;
    waitCyc(5);
    chk("R11 resumed", cntRdData, 8'h55);

    // R11 prescaler frozen too: 1:4, two events before sleep, two after
    wrCfg(7'h01);
    wrCnt(8'h00);
    waitCyc(4);
    sleepIn = 1'b1;
    waitCyc(6);
    sleepIn = 1'b0;
    waitCyc(1);
    chk("R11 prescaler held", cntRdData, 8'h00);
    waitCyc(1);
    chk("R11 prescaler resumed", cntRdData, 8'h01);

    // R8 assignment change restarts the prescaler
    wrCfg(7'h01);
    wrCnt(8'h00);
    waitCyc(4);
    @(negedge clk); cfgWrEn = 1'b1; cfgWrData = 7'h09;
    @(negedge clk); cfgWrData = 7'h01;
    @(negedge clk); cfgWrEn = 1'b0;
    snap = cntRdData;
    waitCyc(3);
    chk("R8 restart after reassign", cntRdData, snap);
    waitCyc(1);
    chk("R8 fourth event counts", cntRdData, 8'(snap + 8'd1));

    finishRun();
  end
endmodule